// File: doc/BRIEF.md
# Far-End Path Defect Status Register

This block keeps the management-visible record of remote path defects reported by the far end of a path. Two level inputs arrive from the receive defect detector: one for a remote payload defect (payload mismatch or loss of cell delineation), and one for a remote server defect. The remote end signals alarm-indication and loss-of-pointer with the same code, so they cannot be told apart and share one server defect bit. Each defect sets its own bit in a 16-bit status word. The bit then stays set until software clears it.

Software sees the current word on a read port and marks the moment of each read with a strobe. It clears bits through a clear strobe that comes with a per-bit mask. The clear is atomic with respect to defect events. A bit whose defect input was asserted after the most recent read, or in the same cycle as the clear, survives the clear. Software therefore always sees a transient at least once before it can erase it. A defect held high keeps setting its bit, so clearing it has no lasting effect.

Reset is asserted asynchronously and released in step with the clock. It empties every latched bit.

Top module: `far_end_path_status`

## Requirements
- R1: After reset the status word reads 0x0000.
- R2: A high level on the payload defect input sets bit 10 of the status word at the next clock edge, and the bit stays set after the input returns low.
- R3: A high level on the server defect input sets bit 8 of the status word at the next clock edge, and the bit stays set after the input returns low.
- R4: Bit 9 and every bit other than 8 and 10 always read zero, whatever the defect inputs or the clear mask do.
- R5: A clear strobe clears only the latched bits whose mask bit is 1. Mask bit 10 selects the payload bit and mask bit 8 selects the server bit. Bits not selected keep their value.
- R6: When a defect input is high in the same cycle as a clear that selects its bit, the bit is 1 after that edge. A defect held high keeps its bit set across repeated clears.
- R7: A bit whose defect input was high in any cycle after the last read strobe (the read cycle itself included) is not cleared by a clear strobe without a read. A clear issued in the same cycle as a read is protected only by sets in that cycle.
- R8: A read strobe on its own does not change the status word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| payload_defect_i | input | 1 | Remote payload defect level |
| server_defect_i | input | 1 | Remote server defect level |
| rd_en_i | input | 1 | Marks the cycle in which software samples the word |
| rd_data_o | output | 16 | Current latched status word |
| clr_en_i | input | 1 | Clear strobe |
| clr_mask_i | input | 16 | Bits to clear when the clear strobe is high |

## Verification
The assertions assume that the defect inputs and strobes are synchronous to the clock and stable around each rising edge. They also assume that a clear directly following a read-free set cycle is the pattern in which protection must hold. The bench drives every input on the falling edge and samples the word on the next falling edge, one register stage after the stimulus. Its scenarios hold defect pulses to whole cycles, so each set, read and clear lands in a single, known edge.

// File: rtl/fesr_pkg.sv
package fesr_pkg;
  localparam int unsigned WORD_W      = 16;
  localparam int unsigned PAYLOAD_POS = 10;
  localparam int unsigned SERVER_POS  = 8;
  localparam int unsigned RSVD_POS    = 9;
  localparam int unsigned NUM_DEF     = 2;
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic [0:0] {
    DEF_PAYLOAD = 1'b0,
    DEF_SERVER  = 1'b1
  } def_idx_e;
endpackage

// File: rtl/fesr_rst_sync.sv
module fesr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/fesr_bit_cell.sv
module fesr_bit_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic rd_i,
  input  logic clr_i,
  output logic stat_o
);
  logic stat_q, stat_d;
  logic fresh_q, fresh_d;
  logic guard;
  logic upd_en;

  // Bits set after the last read are guarded against a clear.
  always_comb begin
    guard   = rd_i ? 1'b0 : fresh_q;
    stat_d  = (stat_q & ~(clr_i & ~guard)) | set_i;
    fresh_d = rd_i ? set_i : (fresh_q | set_i);
    upd_en  = set_i | rd_i | clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= 1'b0;
      fresh_q <= 1'b0;
    end else if (upd_en) begin
      stat_q  <= stat_d;
      fresh_q <= fresh_d;
    end
  end

  assign stat_o = stat_q;

  // R2
  set_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> stat_q);

  // R5
  hold_no_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q && !clr_i) |=> stat_q);

  // R5
  clr_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !set_i) |=> ((clr_i && !set_i) |=> !stat_q));

  // R7
  protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !rd_i) |=> ((clr_i && !rd_i) |=> stat_q));

  // R8
  read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !clr_i && !set_i) |=> $stable(stat_q));
endmodule

// File: rtl/fesr_word_map.sv
module fesr_word_map #(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned PAYLOAD_POS = 10,
  parameter int unsigned SERVER_POS  = 8
) (
  input  logic              stat_pay_i,
  input  logic              stat_srv_i,
  input  logic              clr_en_i,
  input  logic [WORD_W-1:0] clr_mask_i,
  output logic [WORD_W-1:0] word_o,
  output logic              clr_pay_o,
  output logic              clr_srv_o
);
  for (genvar j = 0; j < WORD_W; j++) begin : g_bit
    if (j == PAYLOAD_POS) begin : g_pay
      assign word_o[j] = stat_pay_i;
    end else if (j == SERVER_POS) begin : g_srv
      assign word_o[j] = stat_srv_i;
    end else begin : g_zero
      assign word_o[j] = 1'b0;
    end
  end

  assign clr_pay_o = clr_en_i & clr_mask_i[PAYLOAD_POS];
  assign clr_srv_o = clr_en_i & clr_mask_i[SERVER_POS];
endmodule

// File: rtl/far_end_path_status.sv
module far_end_path_status
  import fesr_pkg::*;
#(
  parameter int unsigned W    = WORD_W,
  parameter int unsigned PPOS = PAYLOAD_POS,
  parameter int unsigned SPOS = SERVER_POS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         payload_defect_i,
  input  logic         server_defect_i,
  input  logic         rd_en_i,
  output logic [W-1:0] rd_data_o,
  input  logic         clr_en_i,
  input  logic [W-1:0] clr_mask_i
);
  localparam logic [W-1:0] LIVE_MASK = (W'(1) << PPOS) | (W'(1) << SPOS);

  logic               rst_sync_n;
  logic [NUM_DEF-1:0] set_vec;
  logic [NUM_DEF-1:0] clr_vec;
  logic [NUM_DEF-1:0] stat_vec;

  fesr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign set_vec[DEF_PAYLOAD] = payload_defect_i;
  assign set_vec[DEF_SERVER]  = server_defect_i;

  for (genvar i = 0; i < NUM_DEF; i++) begin : g_cell
    fesr_bit_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .set_i  (set_vec[i]),
      .rd_i   (rd_en_i),
      .clr_i  (clr_vec[i]),
      .stat_o (stat_vec[i])
    );
  end

  fesr_word_map #(.WORD_W(W), .PAYLOAD_POS(PPOS), .SERVER_POS(SPOS)) u_map (
    .stat_pay_i (stat_vec[DEF_PAYLOAD]),
    .stat_srv_i (stat_vec[DEF_SERVER]),
    .clr_en_i   (clr_en_i),
    .clr_mask_i (clr_mask_i),
    .word_o     (rd_data_o),
    .clr_pay_o  (clr_vec[DEF_PAYLOAD]),
    .clr_srv_o  (clr_vec[DEF_SERVER])
  );

  // R4
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_data_o & ~LIVE_MASK) == '0);

  // R4
  rsvd_clr_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clr_en_i && ((clr_mask_i & LIVE_MASK) == '0)) |=> $stable(rd_data_o & LIVE_MASK) || $past(payload_defect_i || server_defect_i));

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (payload_defect_i && clr_en_i) |=> rd_data_o[PPOS]);
endmodule

// File: tb/tb_far_end_path_status.sv
`timescale 1ns/1ps
module tb_far_end_path_status;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pay, srv, rd, clr;
  logic [15:0] mask;
  logic [15:0] word;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  far_end_path_status dut (
    .clk              (clk),
    .rst_n            (rst_n),
    .payload_defect_i (pay),
    .server_defect_i  (srv),
    .rd_en_i          (rd),
    .rd_data_o        (word),
    .clr_en_i         (clr),
    .clr_mask_i       (mask)
  );

  task automatic check(input string tag, input logic [15:0] exp);
    checks++;
    if (word !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, word, exp);
    end
  endtask

  // Drive one cycle of stimulus at a falling edge; return at the next falling edge.
  task automatic step(input logic p, input logic s, input logic r,
                      input logic c, input logic [15:0] m);
    pay = p; srv = s; rd = r; clr = c; mask = m;
    @(posedge clk);
    @(negedge clk);
    pay = 0; srv = 0; rd = 0; clr = 0; mask = '0;
  endtask

  task automatic wipe();
    step(0, 0, 1, 0, 16'h0000);
    step(0, 0, 0, 1, 16'hFFFF);
  endtask

  task automatic t_reset();
    check("R1 reset word", 16'h0000);
  endtask

  task automatic t_payload();
    step(1, 0, 0, 0, 16'h0000);
    check("R2 payload sets bit10", 16'h0400);
    step(0, 0, 0, 0, 16'h0000);
    check("R2 payload bit held", 16'h0400);
    wipe();
  endtask

  task automatic t_server();
    step(0, 1, 0, 0, 16'h0000);
    check("R3 server sets bit8", 16'h0100);
    step(0, 0, 0, 0, 16'h0000);
    check("R3 server bit held", 16'h0100);
    wipe();
  endtask

  task automatic t_masked();
    step(1, 1, 0, 0, 16'h0000);
    check("R5 both set", 16'h0500);
    step(0, 0, 1, 0, 16'h0000);
    step(0, 0, 0, 1, 16'h0100);
    check("R5 clear bit8 only", 16'h0400);
    step(0, 0, 0, 1, 16'h0400);
    check("R5 clear bit10", 16'h0000);
  endtask

  task automatic t_reserved();
    step(1, 1, 0, 0, 16'h0000);
    step(0, 0, 1, 0, 16'h0000);
    step(0, 0, 0, 1, 16'hFAFF);
    check("R4 unrelated mask bits ignored", 16'h0500);
    step(0, 0, 0, 1, 16'h0200);
    check("R4 bit9 clear no effect", 16'h0500);
  endtask

  task automatic t_read_only();
    step(0, 0, 1, 0, 16'h0000);
    check("R8 read leaves word", 16'h0500);
    wipe();
    check("R5 wipe clears all", 16'h0000);
  endtask

  task automatic t_set_wins();
    step(0, 1, 0, 1, 16'h0100);
    check("R6 set beats clear", 16'h0100);
    for (int k = 0; k < 3; k++) begin
      step(0, 1, 1, 1, 16'h0100);
      check("R6 held defect survives clear", 16'h0100);
    end
    wipe();
  endtask

  task automatic t_protect();
    step(0, 0, 1, 0, 16'h0000);
    step(1, 0, 0, 0, 16'h0000);
    step(0, 0, 0, 1, 16'h0400);
    check("R7 set after read survives clear", 16'h0400);
    step(0, 0, 1, 0, 16'h0000);
    step(0, 0, 0, 1, 16'h0400);
    check("R7 clear after fresh read", 16'h0000);
    step(0, 1, 0, 0, 16'h0000);
    step(0, 0, 1, 1, 16'h0100);
    check("R7 read with clear removes bit", 16'h0000);
  endtask

  initial begin
    pay = 0; srv = 0; rd = 0; clr = 0; mask = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_payload();
    t_server();
    t_masked();
    t_reserved();
    t_read_only();
    t_set_wins();
    t_protect();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule